// File: doc/BRIEF.md
# Line-Grouped Translation Buffer with Reference Harvesting

This block is a small on-chip address translation store for a processor whose full page map cannot fit on chip. Each entry is a line of page table entries (PTEs) that covers a contiguous run of virtual pages. The upper virtual page bits pick the line and are compared against a stored tag. The lowest virtual page bits pick one PTE within that line, in the same way that a word is picked within a cache line. When a lookup finds no matching line, the block raises a miss fault and reports the faulting virtual address. Software then loads the whole line through a refill write port and retries the access. One fault therefore brings in translations for every page of the line.

Each PTE has a reference bit. The bit is set when a translation through that PTE succeeds, and all reference bits of a line are cleared when the line is refilled. When a refill overwrites a valid line, the old line's tag, index and reference vector are latched into readout registers and a one-cycle valid pulse is raised. Profiling software can then learn which pages of the evicted line were actually used. A saturating counter per line records how many times that line has been loaded, and a select input reads out one counter.

Top module: `tlbg_top`

## Requirements
- R1: After reset, every line is invalid, so any lookup reports a miss fault. The eviction pulse and the response valid are low, and every per-line load counter reads zero.
- R2: A virtual address is split, from the low end upward, into a PAGE_W-bit page offset, a log2(LINE_PTES)-bit PTE index, a log2(NUM_LINES)-bit line index and the remaining tag bits. A hit returns the translated address {PPN of the selected PTE, page offset}.
- R3: Each lookup is answered exactly one cycle later by one response with exactly one of hit, miss fault or page fault set. A lookup whose line is invalid or whose stored tag differs reports a miss fault. The reported fault address is lk_pc for an instruction fetch and lk_addr for a data access, and the same choice of address is the one that is translated.
- R4: After a refill writes a line, retrying the faulting access hits.
- R5: A PTE holds its PPN in bits [PPN_W-1:0] and a valid flag in bit PPN_W. PTE i of a refill line occupies rf_data[i*(PPN_W+1) +: PPN_W+1]. A lookup that matches a valid line but selects a PTE whose valid flag is 0 reports a page fault, not a miss fault.
- R6: One refill serves every page of its line. Lookups to the other PTE indices of that line hit without any further miss.
- R7: A PTE's reference bit is set only by a lookup that hits through it. Page faults and misses leave it clear. A refill clears every reference bit of the line it writes.
- R8: A refill over a valid line raises ev_valid for one cycle, in the cycle after the refill. ev_line, ev_tag and ev_refs then give the old line's index and tag, and bit i of ev_refs is set if and only if PTE i translated successfully since that line was loaded. A refill into an invalid line raises no pulse.
- R9: Each line has a CNT_W-bit load counter that increments on every refill of that line and saturates at 2^CNT_W-1 without wrapping. cnt_val shows the counter of the line chosen by cnt_sel.
- R10: When a lookup and a refill occur in the same cycle, the lookup sees the contents from before the refill. A hit made in that cycle is included in the harvested reference vector of the line being replaced.
- R11: The active-low reset is asynchronous. Asserting it in the middle of operation invalidates all lines and clears the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_is_fetch | input | 1 | 1: instruction fetch (translate lk_pc); 0: data access (translate lk_addr) |
| lk_pc | input | VA_W | Fetch program counter |
| lk_addr | input | VA_W | Data virtual address |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_pa | output | PPN_W+PAGE_W | Translated physical address |
| miss_fault | output | 1 | No matching valid line; software refill required |
| page_fault | output | 1 | Line present, selected PTE invalid |
| fault_va | output | VA_W | Virtual address of the answered lookup |
| rf_we | input | 1 | Refill write strobe |
| rf_line | input | log2(NUM_LINES) | Line index to write |
| rf_tag | input | TAG_W | Tag to store |
| rf_data | input | LINE_PTES*(PPN_W+1) | All PTEs of the line |
| ev_valid | output | 1 | One-cycle eviction pulse |
| ev_line | output | log2(NUM_LINES) | Index of evicted line |
| ev_tag | output | TAG_W | Tag of evicted line |
| ev_refs | output | LINE_PTES | Harvested reference bits of evicted line |
| cnt_sel | input | log2(NUM_LINES) | Load counter select |
| cnt_val | output | CNT_W | Selected line's load counter |

## Verification
The reference bits have no readout of their own, so a reference bit that is set or cleared wrongly stays hidden until its line is evicted. It then shows up as a wrong bit in ev_refs in the cycle after the next refill of that line. For this reason the tests load lines, touch chosen pages and then force an eviction. A corrupt valid bit or tag shows up as a wrong hit or miss on the very next lookup to that line. A counter fault becomes visible on cnt_val in the cycle after a refill, and the saturation test drives one line's counter past its limit.

// File: rtl/tlbg_pkg.sv
package tlbg_pkg;
  typedef enum logic [1:0] {
    RSP_HIT  = 2'd0,
    RSP_MISS = 2'd1,
    RSP_PGF  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/tlbg_store.sv
module tlbg_store #(
  parameter int NUM_LINES = 8,
  parameter int LINE_PTES = 16,
  parameter int TAG_W     = 13,
  parameter int PTE_W     = 21,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int IDX_W    = $clog2(LINE_PTES),
  localparam int DATA_W   = LINE_PTES * PTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [PTE_W-1:0]  rd_pte,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ref_en,
  input  logic [LINE_W-1:0] ref_line,
  input  logic [IDX_W-1:0]  ref_idx,
  output logic              vic_valid,
  output logic [TAG_W-1:0]  vic_tag,
  output logic [LINE_PTES-1:0] vic_refs
);
  logic [NUM_LINES-1:0] valid_q, valid_d;
  logic [LINE_PTES-1:0] refs_q [NUM_LINES];
  logic [LINE_PTES-1:0] refs_d [NUM_LINES];
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [DATA_W-1:0]    data_q [NUM_LINES];
  logic [LINE_PTES-1:0] ref_mask;

  // read side
  always_comb begin
    rd_valid = valid_q[rd_line];
    rd_tag   = tag_q[rd_line];
    rd_pte   = data_q[rd_line][rd_idx*PTE_W +: PTE_W];
  end

  // reference bit that the current cycle's hit will set
  always_comb begin
    ref_mask = '0;
    ref_mask[ref_idx] = ref_en;
  end

  // victim view of the line being overwritten, including a concurrent hit
  always_comb begin
    vic_valid = valid_q[wr_line];
    vic_tag   = tag_q[wr_line];
    vic_refs  = refs_q[wr_line];
    if (ref_en && (ref_line == wr_line)) vic_refs = vic_refs | ref_mask;
  end

  // next state: refill has priority over reference setting
  always_comb begin
    valid_d = valid_q;
    for (int l = 0; l < NUM_LINES; l++) refs_d[l] = refs_q[l];
    if (ref_en) refs_d[ref_line] = refs_q[ref_line] | ref_mask;
    if (wr_en) begin
      valid_d[wr_line] = 1'b1;
      refs_d[wr_line]  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int l = 0; l < NUM_LINES; l++) refs_q[l] <= '0;
    end else begin
      valid_q <= valid_d;
      for (int l = 0; l < NUM_LINES; l++) refs_q[l] <= refs_d[l];
    end
  end

  // payload: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_line]  <= wr_tag;
      data_q[wr_line] <= wr_data;
    end
  end
endmodule

// File: rtl/tlbg_lookup.sv
module tlbg_lookup
  import tlbg_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_W    = 12,
  parameter int PPN_W     = 20,
  parameter int NUM_LINES = 8,
  parameter int LINE_PTES = 16,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int IDX_W    = $clog2(LINE_PTES),
  localparam int TAG_W    = VA_W - PAGE_W - IDX_W - LINE_W,
  localparam int PTE_W    = PPN_W + 1,
  localparam int PA_W     = PPN_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic              lk_is_fetch,
  input  logic [VA_W-1:0]   lk_pc,
  input  logic [VA_W-1:0]   lk_addr,
  output logic [LINE_W-1:0] rd_line,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [PTE_W-1:0]  rd_pte,
  output logic              ref_en,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              miss_fault,
  output logic              page_fault,
  output logic [VA_W-1:0]   fault_va
);
  logic [VA_W-1:0]  va;
  logic [TAG_W-1:0] va_tag;
  logic             line_match;
  rsp_kind_e        kind_d, kind_q;
  logic             vld_d, vld_q;
  logic [PA_W-1:0]  pa_d, pa_q;
  logic [VA_W-1:0]  va_q;

  always_comb begin
    va         = lk_is_fetch ? lk_pc : lk_addr;
    rd_idx     = va[PAGE_W +: IDX_W];
    rd_line    = va[PAGE_W+IDX_W +: LINE_W];
    va_tag     = va[VA_W-1 -: TAG_W];
    line_match = rd_valid && (rd_tag == va_tag);
    if (!line_match)              kind_d = RSP_MISS;
    else if (!rd_pte[PTE_W-1])    kind_d = RSP_PGF;
    else                          kind_d = RSP_HIT;
    ref_en = lk_req && (kind_d == RSP_HIT);
    pa_d   = {rd_pte[PPN_W-1:0], va[PAGE_W-1:0]};
    vld_d  = lk_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= RSP_MISS;
    end else begin
      vld_q <= vld_d;
      if (lk_req) kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_req) begin
      pa_q <= pa_d;
      va_q <= va;
    end
  end

  always_comb begin
    rsp_valid  = vld_q;
    rsp_hit    = vld_q && (kind_q == RSP_HIT);
    miss_fault = vld_q && (kind_q == RSP_MISS);
    page_fault = vld_q && (kind_q == RSP_PGF);
    rsp_pa     = pa_q;
    fault_va   = va_q;
  end
endmodule

// File: rtl/tlbg_stats.sv
module tlbg_stats #(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 8,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [LINE_W-1:0] inc_line,
  input  logic [LINE_W-1:0] sel,
  output logic [CNT_W-1:0]  val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cnt
    logic             bump;
    logic [CNT_W-1:0] cnt_d;
    always_comb begin
      bump  = inc_en && (inc_line == LINE_W'(g)) && (cnt_q[g] != CNT_MAX);
      cnt_d = bump ? cnt_q[g] + 1'b1 : cnt_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q[g] <= '0;
      else if (bump) cnt_q[g] <= cnt_d;
    end
  end

  assign val = cnt_q[sel];
endmodule

// File: rtl/tlbg_evict.sv
module tlbg_evict #(
  parameter int NUM_LINES = 8,
  parameter int LINE_PTES = 16,
  parameter int TAG_W     = 13,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic                 vic_valid,
  input  logic [TAG_W-1:0]     vic_tag,
  input  logic [LINE_PTES-1:0] vic_refs,
  output logic                 ev_valid,
  output logic [LINE_W-1:0]    ev_line,
  output logic [TAG_W-1:0]     ev_tag,
  output logic [LINE_PTES-1:0] ev_refs
);
  logic pulse_d, pulse_q;

  always_comb pulse_d = wr_en && vic_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  always_ff @(posedge clk) begin
    if (pulse_d) begin
      ev_line <= wr_line;
      ev_tag  <= vic_tag;
      ev_refs <= vic_refs;
    end
  end

  assign ev_valid = pulse_q;
endmodule

// File: rtl/tlbg_top.sv
module tlbg_top #(
  parameter int VA_W      = 32,
  parameter int PAGE_W    = 12,
  parameter int PPN_W     = 20,
  parameter int LINE_PTES = 16,
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 8,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int IDX_W    = $clog2(LINE_PTES),
  localparam int TAG_W    = VA_W - PAGE_W - IDX_W - LINE_W,
  localparam int PTE_W    = PPN_W + 1,
  localparam int PA_W     = PPN_W + PAGE_W,
  localparam int DATA_W   = LINE_PTES * PTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_req,
  input  logic                 lk_is_fetch,
  input  logic [VA_W-1:0]      lk_pc,
  input  logic [VA_W-1:0]      lk_addr,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 miss_fault,
  output logic                 page_fault,
  output logic [VA_W-1:0]      fault_va,
  input  logic                 rf_we,
  input  logic [LINE_W-1:0]    rf_line,
  input  logic [TAG_W-1:0]     rf_tag,
  input  logic [DATA_W-1:0]    rf_data,
  output logic                 ev_valid,
  output logic [LINE_W-1:0]    ev_line,
  output logic [TAG_W-1:0]     ev_tag,
  output logic [LINE_PTES-1:0] ev_refs,
  input  logic [LINE_W-1:0]    cnt_sel,
  output logic [CNT_W-1:0]     cnt_val
);
  logic [LINE_W-1:0]    rd_line;
  logic [IDX_W-1:0]     rd_idx;
  logic                 rd_valid;
  logic [TAG_W-1:0]     rd_tag;
  logic [PTE_W-1:0]     rd_pte;
  logic                 ref_en;
  logic                 vic_valid;
  logic [TAG_W-1:0]     vic_tag;
  logic [LINE_PTES-1:0] vic_refs;

  tlbg_lookup #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .PPN_W(PPN_W),
    .NUM_LINES(NUM_LINES), .LINE_PTES(LINE_PTES)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_is_fetch(lk_is_fetch), .lk_pc(lk_pc), .lk_addr(lk_addr),
    .rd_line(rd_line), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_pte(rd_pte),
    .ref_en(ref_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .miss_fault(miss_fault), .page_fault(page_fault), .fault_va(fault_va)
  );

  tlbg_store #(
    .NUM_LINES(NUM_LINES), .LINE_PTES(LINE_PTES), .TAG_W(TAG_W), .PTE_W(PTE_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_line(rd_line), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_pte(rd_pte),
    .wr_en(rf_we), .wr_line(rf_line), .wr_tag(rf_tag), .wr_data(rf_data),
    .ref_en(ref_en), .ref_line(rd_line), .ref_idx(rd_idx),
    .vic_valid(vic_valid), .vic_tag(vic_tag), .vic_refs(vic_refs)
  );

  tlbg_evict #(
    .NUM_LINES(NUM_LINES), .LINE_PTES(LINE_PTES), .TAG_W(TAG_W)
  ) u_evict (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rf_we), .wr_line(rf_line),
    .vic_valid(vic_valid), .vic_tag(vic_tag), .vic_refs(vic_refs),
    .ev_valid(ev_valid), .ev_line(ev_line), .ev_tag(ev_tag), .ev_refs(ev_refs)
  );

  tlbg_stats #(
    .NUM_LINES(NUM_LINES), .CNT_W(CNT_W)
  ) u_stats (
    .clk(clk), .rst_n(rst_n),
    .inc_en(rf_we), .inc_line(rf_line),
    .sel(cnt_sel), .val(cnt_val)
  );
endmodule

// File: rtl/tlbg_chk.sv
module tlbg_chk #(
  parameter int LINE_W = 3,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              miss_fault,
  input logic              page_fault,
  input logic              rf_we,
  input logic              ev_valid,
  input logic [LINE_W-1:0] cnt_sel,
  input logic [CNT_W-1:0]  cnt_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3: one outcome per response, none when idle
  a_r3_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, miss_fault, page_fault}) == 1);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_hit, miss_fault, page_fault} == 3'b000));
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rsp_valid == $past(lk_req)));
  // R8: eviction pulse only follows a refill
  a_r8_ev_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ev_valid) |-> $past(rf_we));
  // R9: counters change only by refill and never wrap
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(rf_we) && $stable(cnt_sel)) |-> $stable(cnt_val));
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $stable(cnt_sel) && $past(cnt_val) == CNT_MAX) |-> cnt_val == CNT_MAX);
endmodule

bind tlbg_top tlbg_chk #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .miss_fault(miss_fault),
  .page_fault(page_fault), .rf_we(rf_we), .ev_valid(ev_valid),
  .cnt_sel(cnt_sel), .cnt_val(cnt_val)
);

// File: tb/tlbg_top_tb.sv
module tlbg_top_tb;
  localparam int VA_W = 32, PAGE_W = 12, PPN_W = 20, LINE_PTES = 16, NUM_LINES = 8, CNT_W = 8;
  localparam int LINE_W = 3, IDX_W = 4, TAG_W = VA_W - PAGE_W - IDX_W - LINE_W;
  localparam int PTE_W = PPN_W + 1, PA_W = PPN_W + PAGE_W, DATA_W = LINE_PTES * PTE_W;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_req, lk_is_fetch;
  logic [VA_W-1:0] lk_pc, lk_addr;
  logic rsp_valid, rsp_hit, miss_fault, page_fault;
  logic [PA_W-1:0] rsp_pa;
  logic [VA_W-1:0] fault_va;
  logic rf_we;
  logic [LINE_W-1:0] rf_line, cnt_sel;
  logic [TAG_W-1:0] rf_tag, ev_tag;
  logic [DATA_W-1:0] rf_data;
  logic ev_valid;
  logic [LINE_W-1:0] ev_line;
  logic [LINE_PTES-1:0] ev_refs;
  logic [CNT_W-1:0] cnt_val;

  int n_checks = 0, n_fail = 0;
  int exp_cnt [NUM_LINES];
  bit done = 0;

  always #2 clk = ~clk;

  tlbg_top #(.VA_W(VA_W), .PAGE_W(PAGE_W), .PPN_W(PPN_W), .LINE_PTES(LINE_PTES),
             .NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] mkva(input logic [TAG_W-1:0] t, input logic [LINE_W-1:0] l,
                                           input logic [IDX_W-1:0] i, input logic [PAGE_W-1:0] o);
    return {t, l, i, o};
  endfunction

  function automatic logic [DATA_W-1:0] mkline(input logic [PPN_W-1:0] base, input logic [LINE_PTES-1:0] inv);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < LINE_PTES; i++) d[i*PTE_W +: PTE_W] = {~inv[i], base + PPN_W'(i)};
    return d;
  endfunction

  // drive lookup (and optionally refill) for one cycle; results visible at the next negedge
  task automatic cycle(input bit lk, input bit fetch, input logic [VA_W-1:0] pc, input logic [VA_W-1:0] ad,
                       input bit rf, input logic [LINE_W-1:0] line, input logic [TAG_W-1:0] tag,
                       input logic [DATA_W-1:0] data);
    @(negedge clk);
    lk_req = lk; lk_is_fetch = fetch; lk_pc = pc; lk_addr = ad;
    rf_we = rf; rf_line = line; rf_tag = tag; rf_data = data;
    if (rf && exp_cnt[line] < 255) exp_cnt[line]++;
    @(negedge clk);
    lk_req = 0; rf_we = 0;
  endtask

  task automatic look(input bit fetch, input logic [VA_W-1:0] va);
    cycle(1, fetch, fetch ? va : 32'h0, fetch ? 32'h0 : va, 0, '0, '0, '0);
  endtask

  task automatic refill(input logic [LINE_W-1:0] l, input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    cycle(0, 0, '0, '0, 1, l, t, d);
  endtask

  task automatic expect_hit(input string req, input logic [PA_W-1:0] pa);
    chk(rsp_valid && rsp_hit && !miss_fault && !page_fault, req, "hit", {rsp_valid, rsp_hit, miss_fault, page_fault}, 4'b1100);
    chk(rsp_pa == pa, req, "pa", rsp_pa, pa);
  endtask

  task automatic expect_miss(input string req, input logic [VA_W-1:0] va);
    chk(rsp_valid && !rsp_hit && miss_fault && !page_fault, req, "miss", {rsp_valid, rsp_hit, miss_fault, page_fault}, 4'b1010);
    chk(fault_va == va, req, "fault_va", fault_va, va);
  endtask

  task automatic t_reset;
    chk(!rsp_valid, "R1", "rsp_valid", rsp_valid, 0);
    chk(!ev_valid, "R1", "ev_valid", ev_valid, 0);
    for (int l = 0; l < NUM_LINES; l++) begin
      cnt_sel = LINE_W'(l); #1;
      chk(cnt_val == 0, "R1", "counter", cnt_val, 0);
    end
    look(0, mkva(13'h0, 3'd0, 4'd0, 12'h0));
    expect_miss("R1", mkva(13'h0, 3'd0, 4'd0, 12'h0));
  endtask

  task automatic t_miss_sources;
    // fetch reports PC, data reports data address (R3)
    cycle(1, 1, mkva(13'h11, 3'd1, 4'd2, 12'h345), mkva(13'h22, 3'd4, 4'd1, 12'h0), 0, '0, '0, '0);
    expect_miss("R3", mkva(13'h11, 3'd1, 4'd2, 12'h345));
    cycle(1, 0, mkva(13'h11, 3'd1, 4'd2, 12'h345), mkva(13'h22, 3'd4, 4'd1, 12'h9), 0, '0, '0, '0);
    expect_miss("R3", mkva(13'h22, 3'd4, 4'd1, 12'h9));
    @(negedge clk);
    chk(!rsp_valid, "R3", "no response without request", rsp_valid, 0);
  endtask

  task automatic t_refill_retry;
    refill(3'd1, 13'h11, mkline(20'h1000, '0));
    chk(!ev_valid, "R8", "no pulse on invalid line", ev_valid, 0);
    look(1, mkva(13'h11, 3'd1, 4'd2, 12'h345));
    expect_hit("R4", {20'h1002, 12'h345});
    look(0, mkva(13'h11, 3'd1, 4'd15, 12'hfff));
    expect_hit("R2", {20'h100f, 12'hfff});
    for (int i = 0; i < LINE_PTES; i += 5) begin
      look(0, mkva(13'h11, 3'd1, IDX_W'(i), 12'h0a0));
      expect_hit("R6", {20'h1000 + PPN_W'(i), 12'h0a0});
    end
    look(0, mkva(13'h12, 3'd1, 4'd2, 12'h0));
    expect_miss("R3", mkva(13'h12, 3'd1, 4'd2, 12'h0));
  endtask

  task automatic t_refs_harvest;
    refill(3'd2, 13'h5, mkline(20'h2000, 16'h0080));
    look(0, mkva(13'h5, 3'd2, 4'd0, 12'h0));  expect_hit("R7", {20'h2000, 12'h0});
    look(1, mkva(13'h5, 3'd2, 4'd3, 12'h0));  expect_hit("R7", {20'h2003, 12'h0});
    look(0, mkva(13'h5, 3'd2, 4'd15, 12'h0)); expect_hit("R7", {20'h200f, 12'h0});
    look(0, mkva(13'h5, 3'd2, 4'd7, 12'h1));
    chk(page_fault && !miss_fault && !rsp_hit, "R5", "page fault", {page_fault, miss_fault, rsp_hit}, 3'b100);
    chk(fault_va == mkva(13'h5, 3'd2, 4'd7, 12'h1), "R5", "fault_va", fault_va, mkva(13'h5, 3'd2, 4'd7, 12'h1));
    look(0, mkva(13'h6, 3'd2, 4'd3, 12'h0));  expect_miss("R7", mkva(13'h6, 3'd2, 4'd3, 12'h0));
    refill(3'd2, 13'h6, mkline(20'h3000, '0));
    chk(ev_valid, "R8", "pulse", ev_valid, 1);
    chk(ev_line == 3'd2 && ev_tag == 13'h5, "R8", "line/tag", {ev_line, ev_tag}, {3'd2, 13'h5});
    chk(ev_refs == 16'h8009, "R8", "refs", ev_refs, 16'h8009);
    @(negedge clk);
    chk(!ev_valid, "R8", "pulse one cycle", ev_valid, 0);
    refill(3'd2, 13'h7, mkline(20'h4000, '0));
    chk(ev_valid && ev_tag == 13'h6 && ev_refs == 16'h0, "R7", "refs cleared at load", {ev_tag, ev_refs}, {13'h6, 16'h0});
  endtask

  task automatic t_concurrent;
    // refill line 3 while looking it up: lookup sees old (invalid) state
    cycle(1, 0, '0, mkva(13'h9, 3'd3, 4'd4, 12'h0), 1, 3'd3, 13'h9, mkline(20'h5000, '0));
    expect_miss("R10", mkva(13'h9, 3'd3, 4'd4, 12'h0));
    // hit old line 3 in the same cycle it is replaced; hit included in harvest
    cycle(1, 0, '0, mkva(13'h9, 3'd3, 4'd5, 12'h010), 1, 3'd3, 13'ha, mkline(20'h6000, '0));
    expect_hit("R10", {20'h5005, 12'h010});
    chk(ev_valid && ev_refs == 16'h0020 && ev_tag == 13'h9, "R10", "harvest", {ev_tag, ev_refs}, {13'h9, 16'h0020});
    look(0, mkva(13'ha, 3'd3, 4'd5, 12'h0)); expect_hit("R10", {20'h6005, 12'h0});
  endtask

  task automatic t_counters;
    for (int k = 0; k < 300; k++) refill(3'd7, 13'(k), mkline(20'h0, '0));
    for (int l = 0; l < NUM_LINES; l++) begin
      cnt_sel = LINE_W'(l); #1;
      chk(cnt_val == CNT_W'(exp_cnt[l]), "R9", $sformatf("line %0d count", l), cnt_val, exp_cnt[l]);
    end
  endtask

  task automatic t_async_reset;
    @(negedge clk); #1 rst_n = 0; #1;
    cnt_sel = 3'd7; #1;
    chk(cnt_val == 0, "R11", "counter cleared", cnt_val, 0);
    chk(!rsp_valid && !ev_valid, "R11", "outputs low", {rsp_valid, ev_valid}, 0);
    @(negedge clk); rst_n = 1;
    for (int l = 0; l < NUM_LINES; l++) exp_cnt[l] = 0;
    look(0, mkva(13'ha, 3'd3, 4'd5, 12'h0));
    expect_miss("R11", mkva(13'ha, 3'd3, 4'd5, 12'h0));
  endtask

  initial begin
    rst_n = 0; lk_req = 0; lk_is_fetch = 0; lk_pc = '0; lk_addr = '0;
    rf_we = 0; rf_line = '0; rf_tag = '0; rf_data = '0; cnt_sel = '0;
    for (int l = 0; l < NUM_LINES; l++) exp_cnt[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_miss_sources();
    t_refill_retry();
    t_refs_harvest();
    t_concurrent();
    t_counters();
    t_async_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule